// File: doc/BRIEF.md
# Sampling Delay Sweep Tuner

The tuner finds a good 8-bit sampling delay for one of two receive paths of a card interface: the command line or the data read path. Once started, it walks the delay code over every value from 0 to 255. For each code it places the code into the matching byte of a 32-bit delay word. It then asks an external agent to run one probe transaction and records whether that probe passed.

The tuner does not store per-code results. It tracks passing windows as the results arrive. When the sweep ends it takes the longest unbroken window of passing codes, picks the code at its centre, and merges that code into the delay word. If no code passed, it flags an error and drives the delay word it was given at start. Before the first probe it also clears the four compensation enable bits of a companion DLL configuration word.

Top module: `dly_sweep_tuner`

## Requirements
- R1: After `start_i`, exactly 256 probes are requested, one for each delay code in ascending order from 0 to 255. `probe_req_o` stays high until a probe response is accepted.
- R2: In command mode (`mode_i` = 0), the code under test appears in `dly_word_o[15:8]` while its probe is requested. All other bits equal the `base_word_i` value captured at start.
- R3: In data mode (`mode_i` = 1), the code under test appears in `dly_word_o[23:16]` while its probe is requested. All other bits equal the captured base word.
- R4: At start, `dll_cfg_o` loads `dll_cfg_i` with bits [27:24] forced to zero, and it holds that value for the whole sweep.
- R5: The chosen code is E - (L-1)/2 with integer division, where E is the last code and L is the length of the longest run of passing codes.
- R6: A passing run that is still open at code 255 is closed at the end of the sweep and competes for longest.
- R7: When two runs have equal length, the earlier run is chosen.
- R8: If no code passes, `err_o` is 1 when `done_o` pulses, and `dly_word_o` equals the captured base word.
- R9: On success, `err_o` is 0 and `dly_word_o` is the base word with the chosen code in the mode's field (bits [15:8] in command mode, bits [23:16] in data mode).
- R10: `done_o` is high for exactly one cycle, the cycle after the final word is written. `busy_o` is low in that cycle.
- R11: A response on `probe_ack_i` while `probe_req_o` is low is ignored. It neither advances the sweep nor records a pass.
- R12: After reset, `dly_word_o`, `dll_cfg_o`, `probe_req_o`, `busy_o`, `done_o` and `err_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start a sweep (taken only when idle) |
| mode_i | input | 1 | 0 = command path, 1 = data path |
| base_word_i | input | 32 | Stored delay word, captured at start |
| dll_cfg_i | input | 32 | DLL configuration, captured at start |
| probe_req_o | output | 1 | Probe requested for the current code |
| probe_ack_i | input | 1 | Probe response valid |
| probe_pass_i | input | 1 | Probe result, 1 = pass |
| dly_word_o | output | 32 | Delay word under test, or the final word |
| dll_cfg_o | output | 32 | DLL configuration with compensation cleared |
| busy_o | output | 1 | Sweep in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | No passing code found |

## Verification
The response to code 255 lands in the same cycle that the open run must close and be compared with the best run seen so far. Windows that run up to code 255, and all-pass maps, make the final result depend on both at once; the bench checks the centre code computed from that closed run. A stray response can also arrive in the same cycle that the next code is being written. The bench drives passing stray responses into the one-cycle gaps between requests of an all-failing sweep, and judges that the result is still an error, with exactly 256 probes in code order.

// File: rtl/dst_pkg.sv
package dst_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_CLR  = 3'd1,
    ST_SET  = 3'd2,
    ST_REQ  = 3'd3,
    ST_FIN  = 3'd4,
    ST_DONE = 3'd5
  } st_e;

  typedef enum logic {
    MODE_CMD  = 1'b0,
    MODE_DATA = 1'b1
  } mode_e;
endpackage

// File: rtl/dst_word_merge.sv
module dst_word_merge #(
  parameter int WORD_W   = 32,
  parameter int CODE_W   = 8,
  parameter int CMD_LSB  = 8,
  parameter int DATA_LSB = 16
) (
  input  logic [WORD_W-1:0] word_i,
  input  logic [CODE_W-1:0] code_i,
  input  dst_pkg::mode_e    mode_i,
  output logic [WORD_W-1:0] word_o
);
  always_comb begin
    word_o = word_i;
    if (mode_i == dst_pkg::MODE_DATA) word_o[DATA_LSB +: CODE_W] = code_i;
    else                              word_o[CMD_LSB  +: CODE_W] = code_i;
  end
endmodule

// File: rtl/dst_window_track.sv
module dst_window_track #(
  parameter int CODE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              valid_i,
  input  logic              pass_i,
  input  logic [CODE_W-1:0] code_i,
  output logic              found_o,
  output logic [CODE_W-1:0] pick_o
);
  localparam int LEN_W = CODE_W + 1;
  localparam logic [CODE_W-1:0] LAST = {CODE_W{1'b1}};

  logic [LEN_W-1:0]  cur_len_q, best_len_q, len_sel, len_m1;
  logic [CODE_W-1:0] best_end_q, end_sel;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_len_q  <= '0;
      best_len_q <= '0;
      best_end_q <= '0;
    end else if (clear_i) begin
      cur_len_q  <= '0;
      best_len_q <= '0;
      best_end_q <= '0;
    end else if (valid_i) begin
      if (pass_i) begin
        cur_len_q <= cur_len_q + LEN_W'(1);
      end else begin
        // strict compare keeps the earlier run on ties
        if (cur_len_q > best_len_q) begin
          best_len_q <= cur_len_q;
          best_end_q <= code_i - CODE_W'(1);
        end
        cur_len_q <= '0;
      end
    end
  end

  // close a run still open at the last code
  always_comb begin
    if (cur_len_q > best_len_q) begin
      len_sel = cur_len_q;
      end_sel = LAST;
    end else begin
      len_sel = best_len_q;
      end_sel = best_end_q;
    end
    len_m1  = len_sel - LEN_W'(1);
    found_o = (len_sel != '0);
    pick_o  = end_sel - CODE_W'(len_m1 >> 1);
  end
endmodule

// File: rtl/dst_ctrl.sv
module dst_ctrl #(
  parameter int CODE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              ack_i,
  output dst_pkg::st_e      st_o,
  output logic [CODE_W-1:0] code_o,
  output logic              load_o,
  output logic              set_o,
  output logic              take_o,
  output logic              fin_o
);
  import dst_pkg::*;

  st_e               st_q, st_d;
  logic [CODE_W-1:0] cnt_q;
  logic              last;

  assign last   = &cnt_q;
  assign load_o = (st_q == ST_IDLE) && start_i;
  assign set_o  = (st_q == ST_SET);
  assign take_o = (st_q == ST_REQ) && ack_i;
  assign fin_o  = (st_q == ST_FIN);
  assign st_o   = st_q;
  assign code_o = cnt_q;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (start_i) st_d = ST_CLR;
      ST_CLR:  st_d = ST_SET;
      ST_SET:  st_d = ST_REQ;
      ST_REQ:  if (ack_i) st_d = last ? ST_FIN : ST_SET;
      ST_FIN:  st_d = ST_DONE;
      ST_DONE: st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
    end else begin
      st_q <= st_d;
      if (load_o)               cnt_q <= '0;
      else if (take_o && !last) cnt_q <= cnt_q + CODE_W'(1);
    end
  end
endmodule

// File: rtl/dly_sweep_tuner.sv
module dly_sweep_tuner #(
  parameter int WORD_W   = 32,
  parameter int CODE_W   = 8,
  parameter int CMD_LSB  = 8,
  parameter int DATA_LSB = 16,
  parameter int CPST_LSB = 24,
  parameter int CPST_W   = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              mode_i,
  input  logic [WORD_W-1:0] base_word_i,
  input  logic [WORD_W-1:0] dll_cfg_i,
  output logic              probe_req_o,
  input  logic              probe_ack_i,
  input  logic              probe_pass_i,
  output logic [WORD_W-1:0] dly_word_o,
  output logic [WORD_W-1:0] dll_cfg_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o
);
  import dst_pkg::*;

  st_e               st;
  logic [CODE_W-1:0] code, pick;
  logic              load, set, take, fin, found;
  mode_e             mode_q;
  logic [WORD_W-1:0] base_q, word_q, cfg_q, cfg_clr, word_sweep, word_pick;
  logic              err_q;

  dst_ctrl #(.CODE_W(CODE_W)) i_ctrl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(start_i),
    .ack_i  (probe_ack_i),
    .st_o   (st),
    .code_o (code),
    .load_o (load),
    .set_o  (set),
    .take_o (take),
    .fin_o  (fin)
  );

  dst_window_track #(.CODE_W(CODE_W)) i_track (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clear_i(load),
    .valid_i(take),
    .pass_i (probe_pass_i),
    .code_i (code),
    .found_o(found),
    .pick_o (pick)
  );

  dst_word_merge #(
    .WORD_W(WORD_W), .CODE_W(CODE_W), .CMD_LSB(CMD_LSB), .DATA_LSB(DATA_LSB)
  ) i_merge_sweep (
    .word_i(base_q), .code_i(code), .mode_i(mode_q), .word_o(word_sweep)
  );

  dst_word_merge #(
    .WORD_W(WORD_W), .CODE_W(CODE_W), .CMD_LSB(CMD_LSB), .DATA_LSB(DATA_LSB)
  ) i_merge_pick (
    .word_i(base_q), .code_i(pick), .mode_i(mode_q), .word_o(word_pick)
  );

  always_comb begin
    cfg_clr = dll_cfg_i;
    cfg_clr[CPST_LSB +: CPST_W] = '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= MODE_CMD;
      base_q <= '0;
      word_q <= '0;
      cfg_q  <= '0;
      err_q  <= 1'b0;
    end else if (load) begin
      mode_q <= mode_e'(mode_i);
      base_q <= base_word_i;
      word_q <= base_word_i;
      cfg_q  <= cfg_clr;
      err_q  <= 1'b0;
    end else if (set) begin
      word_q <= word_sweep;
    end else if (fin) begin
      word_q <= found ? word_pick : base_q;
      err_q  <= !found;
    end
  end

  assign probe_req_o = (st == ST_REQ);
  assign busy_o      = (st != ST_IDLE) && (st != ST_DONE);
  assign done_o      = (st == ST_DONE);
  assign err_o       = err_q;
  assign dly_word_o  = word_q;
  assign dll_cfg_o   = cfg_q;
endmodule

// File: rtl/dly_sweep_tuner_chk.sv
module dly_sweep_tuner_chk #(
  parameter int WORD_W   = 32,
  parameter int CODE_W   = 8,
  parameter int CMD_LSB  = 8,
  parameter int DATA_LSB = 16,
  parameter int CPST_LSB = 24,
  parameter int CPST_W   = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              probe_req_o,
  input logic [WORD_W-1:0] dly_word_o,
  input logic [WORD_W-1:0] dll_cfg_o,
  input logic              busy_o,
  input logic              done_o,
  input logic              err_o
);
  localparam logic [WORD_W-1:0] FMASK = {{(WORD_W-CODE_W){1'b0}}, {CODE_W{1'b1}}};
  localparam logic [WORD_W-1:0] KEEP  = ~((FMASK << CMD_LSB) | (FMASK << DATA_LSB));

  // R1: probes only inside a sweep
  a_r1_req_in_sweep: assert property (@(posedge clk_i) disable iff (!rst_ni)
    probe_req_o |-> busy_o);

  // R4: compensation field held clear during sweep
  a_r4_cfg_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (dll_cfg_o[CPST_LSB +: CPST_W] == '0));

  // R2/R3: bits outside both code fields never move during a sweep
  a_r2_keep_bits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> ((dly_word_o & KEEP) == ($past(dly_word_o) & KEEP)));

  a_r10_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r10_done_at_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o);

  a_r8_err_with_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_o) |-> done_o);
endmodule

bind dly_sweep_tuner dly_sweep_tuner_chk #(
  .WORD_W(WORD_W), .CODE_W(CODE_W), .CMD_LSB(CMD_LSB),
  .DATA_LSB(DATA_LSB), .CPST_LSB(CPST_LSB), .CPST_W(CPST_W)
) i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .probe_req_o(probe_req_o),
  .dly_word_o (dly_word_o),
  .dll_cfg_o  (dll_cfg_o),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .err_o      (err_o)
);

// File: tb/test_dly_sweep_tuner.sv
module test_dly_sweep_tuner;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic        mode_i = 1'b0;
  logic [31:0] base_word_i = '0;
  logic [31:0] dll_cfg_i = '0;
  logic        probe_ack_i = 1'b0;
  logic        probe_pass_i = 1'b0;
  logic        probe_req_o, busy_o, done_o, err_o;
  logic [31:0] dly_word_o, dll_cfg_o;

  dly_sweep_tuner i_dly_sweep_tuner (.*);

  initial forever #(CLK_PERIOD/2) clk_i = ~clk_i;

  int n_chk = 0;
  int n_fail = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    n_fail++; n_chk++;
    $display("FAIL watchdog actual=0x0 expected=0x1");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  logic [255:0] pmap;
  int           n_probe, n_badcode, n_badkeep;
  bit           cfg_ok, fin_err, fin_busy, done_again;
  logic [31:0]  fin_word;

  // independent reference: longest run, earliest on ties, centre = start + len/2
  task automatic ref_pick(input logic [255:0] m, output bit ok, output int pk);
    int best_s = 0, best_l = 0, i = 0;
    while (i < 256) begin
      if (m[i]) begin
        int s = i;
        while (i < 256 && m[i]) i++;
        if (i - s > best_l) begin best_l = i - s; best_s = s; end
      end else i++;
    end
    ok = best_l > 0;
    pk = best_s + best_l / 2;
  endtask

  task automatic sweep(input bit md, input logic [31:0] base, input logic [31:0] cfg,
                       input int lat, input bit stray);
    int wait_n = 0;
    int lsb = md ? 16 : 8;
    logic [31:0] keep = ~(32'hFF << lsb);
    n_probe = 0; n_badcode = 0; n_badkeep = 0; cfg_ok = 1;
    @(negedge clk_i);
    mode_i = md; base_word_i = base; dll_cfg_i = cfg; start_i = 1;
    @(negedge clk_i);
    start_i = 0; base_word_i = ~base; dll_cfg_i = ~cfg;
    while (!done_o) begin
      probe_ack_i = 0; probe_pass_i = 0;
      if (probe_req_o) begin
        int code = int'((dly_word_o >> lsb) & 32'hFF);
        if (wait_n == 0) begin
          if (code != n_probe) n_badcode++;
          if ((dly_word_o & keep) != (base & keep)) n_badkeep++;
          if (dll_cfg_o != (cfg & 32'hF0FF_FFFF)) cfg_ok = 0;
        end
        if (wait_n >= lat) begin
          probe_ack_i = 1; probe_pass_i = pmap[code];
          n_probe++; wait_n = 0;
        end else wait_n++;
      end else if (stray && busy_o) begin
        probe_ack_i = 1; probe_pass_i = 1;
      end
      @(negedge clk_i);
    end
    probe_ack_i = 0; probe_pass_i = 0;
    fin_word = dly_word_o; fin_err = err_o; fin_busy = busy_o;
    @(negedge clk_i);
    done_again = done_o;
  endtask

  task automatic judge(input bit md, input logic [31:0] base, input string rq);
    bit ok; int pk; logic [31:0] exp_w;
    ref_pick(pmap, ok, pk);
    exp_w = base;
    if (ok) begin
      if (md) exp_w[23:16] = pk[7:0]; else exp_w[15:8] = pk[7:0];
    end
    chk(n_probe == 256 && n_badcode == 0, "R1 probe count/order", n_probe, 256);
    chk(n_badkeep == 0, md ? "R3 data field/other bits" : "R2 cmd field/other bits", n_badkeep, 0);
    chk(cfg_ok, "R4 dll cfg cleared", cfg_ok, 1);
    chk(fin_word == exp_w, rq, fin_word, exp_w);
    chk(fin_err == !ok, ok ? "R9 err low" : "R8 err high", fin_err, !ok);
    chk(!done_again && !fin_busy, "R10 done single pulse, not busy", done_again, 0);
  endtask

  task automatic t_reset;
    chk(dly_word_o == 0 && dll_cfg_o == 0, "R12 reset words", dly_word_o, 0);
    chk(!probe_req_o && !busy_o && !done_o && !err_o, "R12 reset flags",
        {probe_req_o, busy_o, done_o, err_o}, 0);
    // R11: response while idle must not start anything
    probe_ack_i = 1; probe_pass_i = 1;
    @(negedge clk_i); @(negedge clk_i);
    probe_ack_i = 0; probe_pass_i = 0;
    chk(!busy_o && !done_o && dly_word_o == 0, "R11 idle ack ignored", busy_o, 0);
  endtask

  task automatic t_cmd_single;
    pmap = '0;
    for (int i = 40; i <= 90; i++) pmap[i] = 1;
    sweep(0, 32'h1234_5678, 32'hFFFF_FFFF, 0, 0);
    judge(0, 32'h1234_5678, "R5 cmd centre 65");
    chk(fin_word[15:8] == 8'd65, "R5 cmd pick", fin_word[15:8], 65);
  endtask

  task automatic t_data_two;
    pmap = '0;
    for (int i = 10; i <= 19; i++) pmap[i] = 1;
    for (int i = 100; i <= 139; i++) pmap[i] = 1;
    sweep(1, 32'hA5C3_E718, 32'h0F00_00AA, 2, 0);
    judge(1, 32'hA5C3_E718, "R9 data merged word");
    chk(fin_word[23:16] == 8'd120, "R5 data pick", fin_word[23:16], 120);
  endtask

  task automatic t_wrap_end;
    pmap = '0;
    for (int i = 5; i <= 20; i++) pmap[i] = 1;
    for (int i = 200; i <= 255; i++) pmap[i] = 1;
    sweep(0, 32'h0000_0000, 32'h0A00_0000, 1, 0);
    judge(0, 32'h0000_0000, "R6 run to last code");
    chk(fin_word[15:8] == 8'd228, "R6 pick 228", fin_word[15:8], 228);
  endtask

  task automatic t_tie;
    pmap = '0;
    for (int i = 30; i <= 39; i++) pmap[i] = 1;
    for (int i = 60; i <= 69; i++) pmap[i] = 1;
    sweep(1, 32'hFFFF_FFFF, 32'h1234_5678, 0, 0);
    judge(1, 32'hFFFF_FFFF, "R7 tie word");
    chk(fin_word[23:16] == 8'd35, "R7 earlier run kept", fin_word[23:16], 35);
  endtask

  task automatic t_fail_stray;
    pmap = '0;
    sweep(0, 32'hDEAD_BEEF, 32'hFFFF_FFFF, 1, 1);
    judge(0, 32'hDEAD_BEEF, "R8 base word restored");
    chk(fin_err == 1 && n_probe == 256, "R11 stray acks ignored", fin_err, 1);
  endtask

  task automatic t_edges;
    pmap = '0; pmap[0] = 1;
    sweep(1, 32'h0102_0304, 32'h0, 0, 0);
    judge(1, 32'h0102_0304, "R5 single pass at 0");
    pmap = '1;
    sweep(0, 32'h0102_0304, 32'h0, 0, 0);
    judge(0, 32'h0102_0304, "R6 all pass");
    chk(fin_word[15:8] == 8'd128, "R6 all pass pick 128", fin_word[15:8], 128);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);
    t_reset();
    t_cmd_single();
    t_data_two();
    t_wrap_end();
    t_tie();
    t_fail_stray();
    t_edges();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule